// File: doc/BRIEF.md
# Pipelined Uncached Load Unit

This unit issues uncached loads and stores toward a simple synchronous memory, taking at most one request per cycle. A load does not return its own data. When a load is accepted, the unit writes back the data of the load accepted three loads before it. Every access therefore costs one issue cycle, and the memory latency is hidden behind later loads of the same stream. The unit counts only accepted loads. Idle cycles and stores leave untouched the order in which results come back.

Each access takes its address either from the request or from an internal base register. After every accepted access, the base register is loaded with the effective address plus a two's-complement stride, so a stream of base-relative loads walks memory at a constant step. The updated base is shown on a port so that it can be written back to an address register. Loads can fetch one 32-bit word, one 64-bit word, or a full 128-bit quad, which is four 32-bit or two 64-bit values. After a store, the bus needs one idle cycle before it can turn around, so a load requested in the very next cycle is held off with a stall.

The memory port is registered. The memory samples a request one cycle after the unit accepts it, and it returns read data `RD_LAT` cycles after sampling. The unit requires `RD_LAT + 2 <= DEPTH`.

Top module: `ncld_unit`

## Requirements
- R1: A request with `iss_valid=1` and `stall=0` is accepted in that cycle. In the following cycle `mem_req=1` and `mem_addr` holds its effective address. Without an accepted request, `mem_req=0` in the following cycle.
- R2: Each accepted load raises `wb_valid` for exactly one cycle, in the cycle after acceptance, with `wb_tag` equal to that load's `iss_tag`. Stores and idle cycles produce no writeback.
- R3: On the writeback of the n-th accepted load (n > 3), `wb_dvalid=1` and `wb_data` holds the memory line at the effective address of load n-3. The line is read as memory stood when load n-3 was accepted and is masked by load n-3's width.
- R4: The writebacks of the first three loads after reset carry `wb_dvalid=0` and `wb_data=0`.
- R5: Idle cycles and stores between loads do not change which earlier load's data a later load returns.
- R6: The effective address is `iss_addr` when `iss_use_base=0` and the base register when `iss_use_base=1`. On every accepted access the base register becomes effective address + `iss_stride`, modulo 2^AW, and `base_out` shows the new value in the next cycle. Without an accepted access, `base_out` holds its value.
- R7: A load requested in the cycle right after an accepted store raises `stall` and is not accepted: no memory request, no writeback, and no base update. A load requested in any other cycle, and any store, is never stalled.
- R8: Width code `iss_width`: 0 returns bits 31:0, 1 returns bits 63:0, and 2 and 3 return all 128 bits. Bits that are not returned read as zero.
- R9: An accepted store (`iss_is_store=1`) drives `mem_req=1`, `mem_we=1` and `mem_wdata=iss_wdata` in the next cycle, and later loads of that address return the stored line.
- R10: While and right after `rst` is high, `wb_valid`, `mem_req`, `stall` (with no request) and `base_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Access request |
| iss_is_store | input | 1 | 1 = store, 0 = load |
| iss_use_base | input | 1 | Use the internal base register as the address |
| iss_addr | input | AW | Explicit line address |
| iss_stride | input | AW | Two's-complement stride added after the access |
| iss_width | input | 2 | Load width code (R8) |
| iss_tag | input | TW | Destination tag of the load |
| iss_wdata | input | DW | Store data |
| stall | output | 1 | Request is held off by bus turnaround |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory line address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, RD_LAT cycles after sampling |
| wb_valid | output | 1 | Writeback strobe |
| wb_tag | output | TW | Destination of the writeback |
| wb_dvalid | output | 1 | Writeback carries data from a real earlier load |
| wb_data | output | DW | Writeback data |
| base_out | output | AW | Updated base address |

## Verification
If the slot pointer is wrong, or a returning read lands in the wrong slot, the error shows up on `wb_data` when that slot is next read. That happens three loads after the faulty load, however many idle cycles lie between. A turnaround flag that is stuck or badly timed shows on `stall` in the same cycle as the request, and on a missing or extra `mem_req` one cycle later. An error in the base register shows on `base_out` one cycle after the access. It then spreads into the addresses, and so into the data, of every later base-relative load.

// File: rtl/ncld_pkg.sv
package ncld_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    LW_SGL  = 2'd0,
    LW_DBL  = 2'd1,
    LW_QUAD = 2'd2,
    LW_QDBL = 2'd3
  } ld_width_e;
endpackage

// File: rtl/ncld_turnaround.sv
module ncld_turnaround (
  input  logic clk,
  input  logic rst,
  input  logic req_load,
  input  logic store_acc,
  output logic stall
);
  logic after_store_q;

  always_ff @(posedge clk) begin
    if (rst) after_store_q <= 1'b0;
    else     after_store_q <= store_acc;
  end

  assign stall = after_store_q & req_load;
endmodule

// File: rtl/ncld_addr_gen.sv
module ncld_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          use_base,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] base_q
);
  assign ea = use_base ? base_q : addr;

  always_ff @(posedge clk) begin
    if (rst)      base_q <= '0;
    else if (acc) base_q <= ea + stride;
  end
endmodule

// File: rtl/ncld_slot_ring.sv
module ncld_slot_ring
  import ncld_pkg::*;
#(
  parameter int DW     = 128,
  parameter int DEPTH  = 3,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_acc,
  input  ld_width_e     load_width,
  input  logic [DW-1:0] mem_rdata,
  output logic          old_vld,
  output logic [DW-1:0] old_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int L  = RD_LAT + 1;

  logic [PW-1:0] ptr;
  logic [DEPTH-1:0] slot_vld;
  logic [DW-1:0] ram [DEPTH];

  logic          dl_v    [L];
  logic [PW-1:0] dl_slot [L];
  ld_width_e     dl_w    [L];
  logic [DW-1:0] fill_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      slot_vld <= '0;
      old_vld  <= 1'b0;
    end else if (load_acc) begin
      ptr           <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      slot_vld[ptr] <= 1'b1;
      old_vld       <= slot_vld[ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dl_v[0] <= 1'b0;
    else     dl_v[0] <= load_acc;
    dl_slot[0] <= ptr;
    dl_w[0]    <= load_width;
  end

  for (genvar i = 1; i < L; i++) begin : g_dl
    always_ff @(posedge clk) begin
      if (rst) dl_v[i] <= 1'b0;
      else     dl_v[i] <= dl_v[i-1];
      dl_slot[i] <= dl_slot[i-1];
      dl_w[i]    <= dl_w[i-1];
    end
  end

  always_comb begin
    fill_data = '0;
    unique case (dl_w[L-1])
      LW_SGL:  fill_data[WORD_W-1:0]   = mem_rdata[WORD_W-1:0];
      LW_DBL:  fill_data[2*WORD_W-1:0] = mem_rdata[2*WORD_W-1:0];
      default: fill_data               = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dl_v[L-1]) ram[dl_slot[L-1]] <= fill_data;
    if (load_acc)  old_data <= ram[ptr];
  end
endmodule

// File: rtl/ncld_unit.sv
module ncld_unit
  import ncld_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 128,
  parameter int TW     = 5,
  parameter int DEPTH  = 3,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic          iss_is_store,
  input  logic          iss_use_base,
  input  logic [AW-1:0] iss_addr,
  input  logic [AW-1:0] iss_stride,
  input  logic [1:0]    iss_width,
  input  logic [TW-1:0] iss_tag,
  input  logic [DW-1:0] iss_wdata,
  output logic          stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_valid,
  output logic [TW-1:0] wb_tag,
  output logic          wb_dvalid,
  output logic [DW-1:0] wb_data,
  output logic [AW-1:0] base_out
);
  logic          acc_any, load_acc, store_acc;
  logic [AW-1:0] ea;
  logic          old_vld;
  logic [DW-1:0] old_data;

  assign acc_any   = iss_valid & ~stall;
  assign load_acc  = acc_any & ~iss_is_store;
  assign store_acc = acc_any & iss_is_store;

  ncld_turnaround u_turn (
    .clk       (clk),
    .rst       (rst),
    .req_load  (iss_valid & ~iss_is_store),
    .store_acc (store_acc),
    .stall     (stall)
  );

  ncld_addr_gen #(.AW(AW)) u_agen (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc_any),
    .use_base (iss_use_base),
    .addr     (iss_addr),
    .stride   (iss_stride),
    .ea       (ea),
    .base_q   (base_out)
  );

  ncld_slot_ring #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .load_acc   (load_acc),
    .load_width (ld_width_e'(iss_width)),
    .mem_rdata  (mem_rdata),
    .old_vld    (old_vld),
    .old_data   (old_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wb_valid  <= 1'b0;
      wb_tag    <= '0;
    end else begin
      mem_req  <= acc_any;
      mem_we   <= store_acc;
      wb_valid <= load_acc;
      if (acc_any)   mem_addr  <= ea;
      if (store_acc) mem_wdata <= iss_wdata;
      if (load_acc)  wb_tag    <= iss_tag;
    end
  end

  assign wb_dvalid = old_vld;
  assign wb_data   = old_vld ? old_data : '0;
endmodule

// File: rtl/ncld_unit_chk.sv
module ncld_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          iss_valid,
  input logic          iss_is_store,
  input logic          stall,
  input logic          mem_req,
  input logic          mem_we,
  input logic          wb_valid,
  input logic          wb_dvalid,
  input logic [DW-1:0] wb_data,
  input logic [AW-1:0] base_out
);
  logic acc;
  assign acc = iss_valid & ~stall;

  assert_req_follows_R1: assert property (@(posedge clk) disable iff (rst)
    acc |=> mem_req);
  assert_no_req_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !mem_req);
  assert_wb_after_load_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && !iss_is_store) |=> wb_valid);
  assert_wb_only_load_R2: assert property (@(posedge clk) disable iff (rst)
    !(acc && !iss_is_store) |=> !wb_valid);
  assert_invalid_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_dvalid) |-> wb_data == '0);
  assert_base_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(base_out));
  assert_stall_load_only_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> (iss_valid && !iss_is_store));
  assert_stall_after_store_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> $past(iss_valid && iss_is_store));
  assert_store_write_R9: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_is_store) |=> (mem_req && mem_we));
endmodule

bind ncld_unit ncld_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .iss_valid    (iss_valid),
  .iss_is_store (iss_is_store),
  .stall        (stall),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .wb_valid     (wb_valid),
  .wb_dvalid    (wb_dvalid),
  .wb_data      (wb_data),
  .base_out     (base_out)
);

// File: tb/ncld_unit_test.sv
module ncld_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 128, TW = 5, DEPTH = 3;

  logic clk = 0, rst = 1;
  logic iss_valid = 0, iss_is_store = 0, iss_use_base = 0;
  logic [AW-1:0] iss_addr = '0, iss_stride = '0;
  logic [1:0] iss_width = '0;
  logic [TW-1:0] iss_tag = '0;
  logic [DW-1:0] iss_wdata = '0;
  logic stall, mem_req, mem_we, wb_valid, wb_dvalid;
  logic [AW-1:0] mem_addr, base_out;
  logic [DW-1:0] mem_wdata, wb_data;
  logic [DW-1:0] mem_rdata = '0;
  logic [TW-1:0] wb_tag;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ncld_unit #(.AW(AW), .DW(DW), .TW(TW), .DEPTH(DEPTH), .RD_LAT(1)) uut (.*);

  function automatic logic [DW-1:0] pat(int i);
    return {32'hA000_0000 + i, 32'hB000_0000 ^ (i << 4), 32'hC0DE_0000 + i*3, 32'h1234_0000 | i};
  endfunction

  logic [DW-1:0] mem_arr [1<<AW];
  logic [DW-1:0] ref_mem [1<<AW];
  initial for (int i = 0; i < (1<<AW); i++) begin mem_arr[i] = pat(i); ref_mem[i] = pat(i); end

  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem_arr[mem_addr] <= mem_wdata;
    else        mem_rdata <= mem_arr[mem_addr];
  end

  function automatic logic [DW-1:0] msk(logic [DW-1:0] d, logic [1:0] w);
    case (w)
      2'd0: return {96'b0, d[31:0]};
      2'd1: return {64'b0, d[63:0]};
      default: return d;
    endcase
  endfunction

  task automatic chk(bit ok, string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  logic [DW-1:0] q[$];
  logic [AW-1:0] ref_base = '0;
  bit ref_prev_store = 0;

  // One clock: drive, check stall, update model, compare outputs after the edge.
  task automatic go(bit v, bit st, bit ub, int a, int s, int w, int tag, logic [DW-1:0] wd, string r);
    bit exp_stall, acc, exp_wbv, exp_dv;
    logic [AW-1:0] ea;
    logic [DW-1:0] exp_d;
    iss_valid = v; iss_is_store = st; iss_use_base = ub; iss_addr = AW'(a);
    iss_stride = AW'(s); iss_width = 2'(w); iss_tag = TW'(tag); iss_wdata = wd;
    #1;
    exp_stall = ref_prev_store && v && !st;
    chk(stall == exp_stall, {r, " R7 stall"}, DW'(stall), DW'(exp_stall));
    acc = v && !exp_stall;
    ea = ub ? ref_base : AW'(a);
    exp_wbv = acc && !st; exp_dv = 0; exp_d = '0;
    if (acc) begin
      ref_base = ea + AW'(s);
      if (st) ref_mem[ea] = wd;
      else begin
        q.push_back(msk(ref_mem[ea], 2'(w)));
        if (q.size() > DEPTH) begin exp_dv = 1; exp_d = q.pop_front(); end
      end
    end
    ref_prev_store = acc && st;
    @(posedge clk); @(negedge clk);
    chk(wb_valid == exp_wbv, {r, " R2 wb_valid"}, DW'(wb_valid), DW'(exp_wbv));
    chk(mem_req == acc, {r, " R1 mem_req"}, DW'(mem_req), DW'(acc));
    if (acc) chk(mem_addr == ea, {r, " R1 mem_addr"}, DW'(mem_addr), DW'(ea));
    if (acc && st) chk(mem_we && mem_wdata == wd, {r, " R9 store port"}, mem_wdata, wd);
    chk(base_out == ref_base, {r, " R6 base_out"}, DW'(base_out), DW'(ref_base));
    if (exp_wbv) begin
      chk(wb_tag == TW'(tag), {r, " R2 tag"}, DW'(wb_tag), DW'(tag));
      chk(wb_dvalid == exp_dv, {r, " R3/R4 dvalid"}, DW'(wb_dvalid), DW'(exp_dv));
      chk(wb_data == exp_d, {r, " R3/R8 data"}, wb_data, exp_d);
    end
  endtask

  task automatic idle(string r);
    go(0, 0, 0, 0, 0, 0, 0, '0, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wb_valid == 0 && mem_req == 0 && stall == 0 && base_out == 0, "R10 reset", DW'(base_out), '0);
    rst = 0;
    // R4 first three invalid, R8 widths, R3 three-back data
    go(1, 0, 0, 5, 0, 2, 1, '0, "R4 ld1");
    go(1, 0, 0, 9, 0, 0, 2, '0, "R4 ld2");
    go(1, 0, 0, 2, 0, 1, 3, '0, "R4 ld3");
    go(1, 0, 0, 7, 0, 3, 4, '0, "R3 ld4");
    go(1, 0, 0, 1, 0, 2, 5, '0, "R8 ld5");
    // R5 idle cycles do not shift
    idle("R5 idle"); idle("R5 idle");
    go(1, 0, 0, 3, 0, 2, 6, '0, "R5 ld6");
    // R7 turnaround, R9 store then read back
    go(1, 1, 0, 20, 0, 0, 0, {4{32'hFEED_0001}}, "R9 st");
    go(1, 0, 0, 20, 0, 2, 7, '0, "R7 stalled");
    go(1, 0, 0, 20, 0, 2, 7, '0, "R7 retry");
    go(1, 1, 0, 21, 0, 0, 0, {4{32'h5555_AAAA}}, "R7 st st1");
    go(1, 1, 0, 22, 0, 0, 0, {4{32'h0F0F_0F0F}}, "R7 st st2");
    go(1, 0, 0, 21, 0, 1, 8, '0, "R7 stalled2");
    go(1, 0, 0, 21, 0, 1, 8, '0, "R7 retry2");
    go(1, 1, 0, 30, 0, 0, 0, {4{32'h1357_9BDF}}, "R7 st3");
    idle("R7 gap");
    go(1, 0, 0, 30, 0, 2, 9, '0, "R7 no stall after gap");
    // R6 strided streams
    go(1, 0, 0, 100, 3, 2, 10, '0, "R6 seed");
    for (int k = 0; k < 4; k++) go(1, 0, 1, 0, 3, 2, 11 + k, '0, "R6 stride+3");
    for (int k = 0; k < 3; k++) go(1, 0, 1, 0, -5, 0, 15 + k, '0, "R6 stride-5");
    go(1, 0, 0, 250, 10, 3, 18, '0, "R6 wrap seed");
    go(1, 0, 1, 0, 1, 1, 19, '0, "R6 wrap");
    idle("R5 idle3");
    for (int k = 0; k < 3; k++) go(1, 0, 0, 22 + k, 0, 2, 20 + k, '0, "R3 drain");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule